// File: doc/BRIEF.md
# Per-Slot Companding Converter with Gain

This block sits in the voice path of a TDM frame of 64 time slots. It can change the sample format of each slot between A-law, µ-law and 14-bit linear. It can also scale the level of each slot in 1 dB steps. A configuration table holds one entry for each slot. The entry sets a conversion mode and a gain code, and each slot's entry is written on its own. Every sample is accepted with its slot index, and one result with the same slot index comes out exactly one clock later.

Any conversion goes through a signed 14-bit linear value, in three steps: expand, apply gain with saturation, then compress. A slot that converts or changes gain delivers its result one frame later. The result is parked in a slot-indexed store, and each sample of that slot returns the value parked by the previous sample of that slot. A slot with no conversion and unity gain takes a direct path, so its only latency is the output register.

Top module: `slot_compander`

## Requirements
- R1: After reset, out_valid is 0 and every slot is configured as pass-through (mode 0, gain code 15). Every stored result is 0, so the first delayed result of any slot since reset is 0x0000.
- R2: A sample accepted while in_valid is 1 produces out_valid = 1 on the following clock, with out_slot equal to the accepted in_slot. When in_valid is 0, out_valid is 0 on the next clock.
- R3: A slot in mode 0 or mode 7 with gain code 15 is direct: out_data equals the accepted in_data, all 16 bits, one clock later.
- R4: Any other slot is delayed. Its output is the result computed from the previous sample accepted for the same slot index (0x0000 if there was none), and the current result is stored in its place.
- R5: Mode encoding: 1 = A-law to µ-law, 2 = µ-law to A-law, 3 = A-law to linear, 4 = µ-law to linear, 5 = linear to µ-law, 6 = linear to A-law. Law codes use bits [7:0]; a law output has bits [15:8] = 0. A linear value is the two's-complement number in bits [15:2]; a linear output has bits [1:0] = 0.
- R6: Expansion to linear. For µ-law, take u = ~code, e = u[6:4], m = u[3:0]. The magnitude is ((2m+33)<<e)-33, and the value is negative when u[7] = 1. For A-law, take u = code ^ 0x55, e = u[6:4], m = u[3:0]. The magnitude is 4m+2 when e = 0, and (2m+33)<<e otherwise. The value is positive when u[7] = 1.
- R7: Compression from linear value x. For µ-law, clamp |x| to 8158 and add 33 to get b. Then seg = floor(log2 b) - 5 and man = (b >> (seg+1)) & 15, and the code is the inverse of {x<0, seg, man}. For A-law, take h = |x|>>1 clamped to 4095. If h < 32, seg = 0 and man = h>>1. Otherwise seg = floor(log2 h) - 4 and man = (h>>seg) & 15. The code is {x>=0, seg, man} ^ 0x55. Between the two laws (modes 1 and 2), the result is the expansion of the input code followed by this compression.
- R8: Gain code g (0..31) selects a gain of g-15 dB. The multiplier is M = round(16384 * 10^((g-15)/20)). The gained value is floor(x*M/16384), saturated to the range -8192..8191, and is applied between expansion and compression. Code 15 leaves the value unchanged.
- R9: Mode 0 or 7 with a gain code other than 15 treats input and output as linear and applies the gain. It takes the delayed path.
- R10: A configuration write takes effect for samples accepted on later clocks. It changes only the addressed slot. A slot switched to direct passes data at once; a slot switched back to delayed returns its last stored result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present this clock |
| in_slot | input | 6 | Time slot of the input sample |
| in_data | input | 16 | Input sample (law code or linear) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 6 | Slot whose configuration is written |
| cfg_mode | input | 3 | Conversion mode code |
| cfg_gain | input | 5 | Gain code, 15 = 0 dB |
| out_valid | output | 1 | Result present |
| out_slot | output | 6 | Time slot of the result |
| out_data | output | 16 | Result sample |

## Verification
The assertions assume that in_slot and cfg_slot are always below the slot count. They also assume that the configuration of a slot is not rewritten on the same clock that a sample for that slot is accepted, since the direct-path check compares against the entry that was read at acceptance. The stimulus keeps slot indices in range and performs each configuration write on a clock with in_valid low. It changes inputs only between clock edges, so every accepted sample sees one settled configuration.

// File: rtl/cmpg_pkg.sv
package cmpg_pkg;

   localparam int LIN_W = 14;

   typedef enum logic [2:0] {
      XM_PASS  = 3'd0,
      XM_A2U   = 3'd1,
      XM_U2A   = 3'd2,
      XM_A2L   = 3'd3,
      XM_U2L   = 3'd4,
      XM_L2U   = 3'd5,
      XM_L2A   = 3'd6,
      XM_SPARE = 3'd7
   } xmode_t;

   typedef struct packed {
      xmode_t     mode;
      logic [4:0] gain;
   } slot_cfg_t;

   localparam logic [4:0] UNITY_GAIN = 5'd15;

   // mu-law code to 14-bit linear
   function automatic logic signed [LIN_W-1:0] mu_to_lin(input logic [7:0] code);
      logic [7:0] u;
      int e, m, mag;
      u   = ~code;
      e   = int'(u[6:4]);
      m   = int'(u[3:0]);
      mag = ((2 * m + 33) << e) - 33;
      return u[7] ? 14'(-mag) : 14'(mag);
   endfunction

   // A-law code to 14-bit linear
   function automatic logic signed [LIN_W-1:0] a_to_lin(input logic [7:0] code);
      logic [7:0] u;
      int e, m, mag;
      u   = code ^ 8'h55;
      e   = int'(u[6:4]);
      m   = int'(u[3:0]);
      mag = (e == 0) ? (4 * m + 2) : ((2 * m + 33) << e);
      return u[7] ? 14'(mag) : 14'(-mag);
   endfunction

   function automatic logic [7:0] lin_to_mu(input logic signed [LIN_W-1:0] x);
      int v, mag, b, seg;
      logic neg;
      v   = int'(x);
      neg = (v < 0);
      mag = neg ? -v : v;
      if (mag > 8158) mag = 8158;
      b   = mag + 33;
      seg = 0;
      for (int s = 1; s < 8; s++)
         if (b >= (32 << s)) seg = s;
      return ~{neg, 3'(seg), 4'(b >> (seg + 1))};
   endfunction

   function automatic logic [7:0] lin_to_a(input logic signed [LIN_W-1:0] x);
      int v, mag, seg, man;
      logic neg;
      v   = int'(x);
      neg = (v < 0);
      mag = (neg ? -v : v) >> 1;
      if (mag > 4095) mag = 4095;
      seg = 0;
      man = mag >> 1;
      if (mag >= 32) begin
         for (int s = 1; s < 8; s++)
            if (mag >= (16 << s)) seg = s;
         man = mag >> seg;
      end
      return {~neg, 3'(seg), 4'(man)} ^ 8'h55;
   endfunction

   // multiplier with 14 fraction bits for (g-15) dB
   function automatic logic [16:0] gain_q14(input logic [4:0] g);
      case (g)
         5'd0:  return 17'd2914;   5'd1:  return 17'd3269;
         5'd2:  return 17'd3668;   5'd3:  return 17'd4115;
         5'd4:  return 17'd4618;   5'd5:  return 17'd5181;
         5'd6:  return 17'd5813;   5'd7:  return 17'd6523;
         5'd8:  return 17'd7318;   5'd9:  return 17'd8211;
         5'd10: return 17'd9213;   5'd11: return 17'd10338;
         5'd12: return 17'd11599;  5'd13: return 17'd13014;
         5'd14: return 17'd14602;  5'd15: return 17'd16384;
         5'd16: return 17'd18383;  5'd17: return 17'd20626;
         5'd18: return 17'd23143;  5'd19: return 17'd25967;
         5'd20: return 17'd29135;  5'd21: return 17'd32690;
         5'd22: return 17'd36679;  5'd23: return 17'd41155;
         5'd24: return 17'd46176;  5'd25: return 17'd51811;
         5'd26: return 17'd58133;  5'd27: return 17'd65226;
         5'd28: return 17'd73185;  5'd29: return 17'd82115;
         5'd30: return 17'd92134;  default: return 17'd103376;
      endcase
   endfunction

endpackage

// File: rtl/cmpg_cfg_table.sv
module cmpg_cfg_table
   import cmpg_pkg::*;
#(
   parameter int SLOTS  = 64,
   parameter int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  slot_cfg_t         wr_entry,
   input  logic [SLOT_W-1:0] rd_slot,
   output slot_cfg_t         rd_entry
);

   slot_cfg_t tbl [SLOTS];

   for (genvar i = 0; i < SLOTS; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            tbl[i] <= '{mode: XM_PASS, gain: UNITY_GAIN};
         else if (wr_en && (wr_slot == SLOT_W'(i)))
            tbl[i] <= wr_entry;
      end
   end

   assign rd_entry = tbl[rd_slot];

   AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> tbl[$past(wr_slot)] == $past(wr_entry)); // R10

endmodule

// File: rtl/cmpg_datapath.sv
module cmpg_datapath
   import cmpg_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  slot_cfg_t         cfg,
   input  logic [DATA_W-1:0] din,
   output logic              direct,
   output logic [DATA_W-1:0] dout
);

   localparam int LOW_PAD = DATA_W - LIN_W;

   logic signed [LIN_W-1:0] lin_src;
   logic signed [LIN_W-1:0] gained;
   int                      prod;
   int                      scaled;

   assign direct = ((cfg.mode == XM_PASS) || (cfg.mode == XM_SPARE)) &&
                   (cfg.gain == UNITY_GAIN);

   // expansion stage
   always_comb begin
      case (cfg.mode)
         XM_A2U, XM_A2L: lin_src = a_to_lin(din[7:0]);
         XM_U2A, XM_U2L: lin_src = mu_to_lin(din[7:0]);
         default:        lin_src = din[DATA_W-1 -: LIN_W];
      endcase
   end

   // gain stage with saturation
   always_comb begin
      prod   = int'(lin_src) * int'(gain_q14(cfg.gain));
      scaled = prod >>> 14;
      if (scaled > 8191)       gained = 14'sd8191;
      else if (scaled < -8192) gained = -14'sd8192;
      else                     gained = 14'(scaled);
   end

   // compression stage
   always_comb begin
      case (cfg.mode)
         XM_A2U, XM_L2U: dout = {(DATA_W-8)'(0), lin_to_mu(gained)};
         XM_U2A, XM_L2A: dout = {(DATA_W-8)'(0), lin_to_a(gained)};
         default:        dout = {gained, LOW_PAD'(0)};
      endcase
   end

   always_comb begin
      AST_UNITY_GAIN: assert (cfg.gain != UNITY_GAIN || gained == lin_src); // R8
   end

endmodule

// File: rtl/cmpg_frame_store.sv
module cmpg_frame_store #(
   parameter int SLOTS          = 64,
   parameter int DATA_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   parameter int SLOT_W         = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [SLOT_W-1:0] in_slot,
   input  logic              direct,
   input  logic [DATA_W-1:0] direct_data,
   input  logic [DATA_W-1:0] conv_data,
   output logic              out_valid,
   output logic [SLOT_W-1:0] out_slot,
   output logic [DATA_W-1:0] out_data
);

   logic [DATA_W-1:0] mem [SLOTS];
   logic              park;

   assign park = in_valid && !direct;

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
         end else if (park) begin
            mem[in_slot] <= conv_data;
         end
      end
   end else begin : g_noclear
      always_ff @(posedge clk) begin
         if (park) mem[in_slot] <= conv_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_slot  <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_slot <= in_slot;
            out_data <= direct ? direct_data : mem[in_slot];
         end
      end
   end

   AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid && (out_slot == $past(in_slot))); // R2
   AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R2
   AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && direct) |=> out_data == $past(direct_data)); // R3

endmodule

// File: rtl/slot_compander.sv
module slot_compander
   import cmpg_pkg::*;
#(
   parameter int SLOTS          = 64,
   parameter int DATA_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   parameter int SLOT_W         = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [SLOT_W-1:0] in_slot,
   input  logic [DATA_W-1:0] in_data,
   input  logic              cfg_we,
   input  logic [SLOT_W-1:0] cfg_slot,
   input  logic [2:0]        cfg_mode,
   input  logic [4:0]        cfg_gain,
   output logic              out_valid,
   output logic [SLOT_W-1:0] out_slot,
   output logic [DATA_W-1:0] out_data
);

   if (SLOTS < 2) begin : g_bad_slots
      $error("slot_compander: SLOTS must be at least 2");
   end
   if (DATA_W != 16) begin : g_bad_width
      $error("slot_compander: DATA_W must be 16");
   end

   slot_cfg_t         wr_entry;
   slot_cfg_t         cur_cfg;
   logic              direct;
   logic [DATA_W-1:0] conv_data;

   assign wr_entry = '{mode: xmode_t'(cfg_mode), gain: cfg_gain};

   cmpg_cfg_table #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_slot  (cfg_slot),
      .wr_entry (wr_entry),
      .rd_slot  (in_slot),
      .rd_entry (cur_cfg)
   );

   cmpg_datapath #(.DATA_W(DATA_W)) u_dp (
      .cfg    (cur_cfg),
      .din    (in_data),
      .direct (direct),
      .dout   (conv_data)
   );

   cmpg_frame_store #(
      .SLOTS(SLOTS), .DATA_W(DATA_W),
      .CLEAR_ON_RESET(CLEAR_ON_RESET), .SLOT_W(SLOT_W)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_slot     (in_slot),
      .direct      (direct),
      .direct_data (in_data),
      .conv_data   (conv_data),
      .out_valid   (out_valid),
      .out_slot    (out_slot),
      .out_data    (out_data)
   );

endmodule

// File: tb/slot_compander_test.sv
`timescale 1ns/1ps
module slot_compander_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [5:0]  in_slot = '0;
   logic [15:0] in_data = '0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_slot = '0;
   logic [2:0]  cfg_mode = '0;
   logic [4:0]  cfg_gain = '0;
   logic        out_valid;
   logic [5:0]  out_slot;
   logic [15:0] out_data;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   slot_compander uut (.*);

   // bench model state
   int          m_mode [64];
   int          m_gain [64];
   logic [15:0] m_store [64];

   logic [5:0]  q_slot [$];
   logic [15:0] q_data [$];
   string       q_tag  [$];

   function automatic int b_exp_u(int c);
      int u, e, m, mag;
      u = (~c) & 255; e = (u >> 4) & 7; m = u & 15;
      mag = (((m << 1) + 33) * (1 << e)) - 33;
      return (u & 128) != 0 ? -mag : mag;
   endfunction

   function automatic int b_exp_a(int c);
      int u, e, m, mag;
      u = (c ^ 'h55) & 255; e = (u >> 4) & 7; m = u & 15;
      mag = (e == 0) ? (4 * m + 2) : ((2 * m + 33) * (1 << e));
      return (u & 128) != 0 ? mag : -mag;
   endfunction

   function automatic int b_cmp_u(int x);
      int mag, b, seg, man, neg;
      neg = (x < 0) ? 1 : 0;
      mag = neg ? -x : x;
      if (mag > 8158) mag = 8158;
      b = mag + 33; seg = 0;
      while (seg < 7 && b >= (64 << seg)) seg++;
      man = (b >> (seg + 1)) & 15;
      return (~((neg << 7) | (seg << 4) | man)) & 255;
   endfunction

   function automatic int b_cmp_a(int x);
      int mag, seg, man, neg;
      neg = (x < 0) ? 1 : 0;
      mag = (neg ? -x : x) >> 1;
      if (mag > 4095) mag = 4095;
      if (mag < 32) begin seg = 0; man = mag >> 1; end
      else begin
         seg = 1;
         while (seg < 7 && mag >= (32 << seg)) seg++;
         man = (mag >> seg) & 15;
      end
      return (((neg ? 0 : 128) | (seg << 4) | man) ^ 'h55) & 255;
   endfunction

   function automatic int b_gain(int x, int g);
      longint p, q;
      int mult;
      mult = $rtoi(16384.0 * (10.0 ** ((g - 15) / 20.0)) + 0.5);
      p = longint'(x) * mult;
      q = p >>> 14;
      if (q > 8191) q = 8191;
      if (q < -8192) q = -8192;
      return int'(q);
   endfunction

   function automatic logic [15:0] b_conv(int mode, int g, logic [15:0] d);
      int x, y;
      logic signed [13:0] lv;
      lv = d[15:2];
      case (mode)
         1, 3:    x = b_exp_a(int'(d[7:0]));
         2, 4:    x = b_exp_u(int'(d[7:0]));
         default: x = int'(lv);
      endcase
      y = b_gain(x, g);
      case (mode)
         1, 5:    return {8'h00, 8'(b_cmp_u(y))};
         2, 6:    return {8'h00, 8'(b_cmp_a(y))};
         default: return {14'(y), 2'b00};
      endcase
   endfunction

   function automatic bit b_direct(int s);
      return (m_mode[s] == 0 || m_mode[s] == 7) && m_gain[s] == 15;
   endfunction

   // R5 layout lives in b_conv; tags name the checked rule
   function automatic string b_tag(int s);
      string t;
      if (b_direct(s)) return "R3";
      t = "R4";
      case (m_mode[s])
         1, 2: t = {t, " R5 R6 R7"};
         3, 4: t = {t, " R5 R6"};
         5, 6: t = {t, " R5 R7"};
         default: t = {t, " R9"};
      endcase
      if (m_gain[s] != 15) t = {t, " R8"};
      return t;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(int s, logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b0; in_valid = 1'b1; in_slot = 6'(s); in_data = d;
      q_slot.push_back(6'(s));
      q_tag.push_back(b_tag(s));
      if (b_direct(s)) q_data.push_back(d);
      else begin
         q_data.push_back(m_store[s]);
         m_store[s] = b_conv(m_mode[s], m_gain[s], d);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0; cfg_we = 1'b0;
   endtask

   task automatic config_slot(int s, int mode, int g);
      @(negedge clk);
      in_valid = 1'b0;
      cfg_we = 1'b1; cfg_slot = 6'(s); cfg_mode = 3'(mode); cfg_gain = 5'(g);
      m_mode[s] = mode; m_gain[s] = g;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // monitor: pops the scoreboard as results appear
   always @(negedge clk) begin
      if (rst_n && !done && out_valid) begin
         if (q_data.size() == 0) begin
            check(1'b0, "R2 unexpected result", 32'(out_slot), 32'hffff_ffff);
         end else begin
            logic [5:0]  es;
            logic [15:0] ed;
            string       et;
            es = q_slot.pop_front();
            ed = q_data.pop_front();
            et = q_tag.pop_front();
            check(out_slot == es, "R2 slot", 32'(out_slot), 32'(es));
            check(out_data == ed, et, 32'(out_data), 32'(ed));
         end
      end
   end

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++; tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int gl [8] = '{15, 31, 0, 21, 9, 15, 28, 3};
      for (int s = 0; s < 64; s++) begin
         m_mode[s] = 0; m_gain[s] = 15; m_store[s] = '0;
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 idle after reset", 32'(out_valid), 32'd0);

      // R1: default table is pass-through for every slot (R3)
      for (int s = 0; s < 64; s++) send(s, 16'($urandom));
      idle();

      // per-slot modes and gains
      for (int s = 0; s < 64; s++) config_slot(s, s % 8, gl[s >> 3]);

      // frames with gaps and full-scale linear extremes (R8 saturation)
      for (int f = 0; f < 8; f++) begin
         for (int s = 0; s < 64; s++) begin
            logic [15:0] d;
            d = (f == 2) ? 16'h7ffc : (f == 3) ? 16'h8000 : 16'($urandom);
            send(s, d);
            if ($urandom % 5 == 0) idle();
         end
      end
      idle();

      // full code sweep on unity-gain conversion slots 1..6
      for (int c = 0; c < 256; c++) begin
         for (int s = 1; s < 7; s++) send(s, (s >= 5) ? 16'($urandom) : 16'(c));
      end
      send(1, 16'h0000);
      idle();

      // R10: reconfigure one slot to direct and back
      config_slot(9, 0, 15);
      send(9, 16'hbeef);
      send(9, 16'h1234);
      idle();
      config_slot(9, 1, 15);
      send(9, 16'h00d5);
      send(9, 16'h002a);
      idle();
      send(8, 16'h4000);   // neighbour slot unaffected by the slot 9 writes
      send(8, 16'hc000);
      idle();

      repeat (3) @(negedge clk);
      check(q_data.size() == 0, "R2 all results delivered",
            32'(q_data.size()), 32'd0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule